// File: doc/BRIEF.md
# Receive Character Buffer with Block Interrupt

This block sits between an asynchronous serial receiver and a host bus. Each character the receiver completes arrives with a one-cycle write strobe, together with its parity-error and framing-error bits. The block stores the character and both error bits in a 16-entry first-in first-out buffer. The host sees the oldest entry on the read outputs and consumes it with a one-cycle read strobe.

The receive interrupt rises for one of two reasons. The first is that the fill level has reached a trigger level the host selects. The second is that characters are waiting and no write or read has happened for three character times. With a high trigger level, a burst of traffic raises one interrupt per block of characters and not one per byte. The timeout ensures that a lone typed character, which never reaches the trigger, still raises an interrupt.

A character that arrives while the buffer is full is discarded, and a sticky overrun flag records the loss.

Top module: `rx_fifo_irq`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `overrun`=0 and `irq`=0.
- R2: Characters leave in arrival order. `rd_char` shows the oldest stored character, and a read strobe moves it to the next one from the following cycle.
- R3: The parity-error and framing-error bits written with a character appear on `rd_perr` and `rd_ferr` while that character is at the head.
- R4: The buffer holds 16 characters. `empty` is 1 exactly when the buffer holds none.
- R5: A write strobe while 16 characters are stored and no read is strobed discards the new character and leaves the stored contents unchanged.
- R6: A discarded write sets `overrun`, which stays at 1 until the next read strobe and is 0 from the cycle after that strobe.
- R7: `trig_sel` selects the trigger level: 0 selects 1, 1 selects 4, 2 selects 8, and 3 selects 14 (the intended default). `irq` is 1 whenever the fill level is at or above the selected level.
- R8: When reads bring the fill level below the trigger and no timeout is pending, `irq` returns to 0.
- R9: While the buffer is not empty, the third `char_tick` pulse with no write or read since the last activity sets a pending timeout, which drives `irq` to 1.
- R10: Every write strobe and every read strobe restarts the count of character ticks from zero.
- R11: A read strobe clears a pending timeout. It is 0 from the next cycle.
- R12: A read strobe while the buffer is empty has no effect on the contents or the flags.
- R13: A write and a read strobed in the same cycle on a full buffer both take effect, and `overrun` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle strobe: the receiver has a character |
| wr_char | input | 8 | Received character |
| wr_perr | input | 1 | Parity error seen on that character |
| wr_ferr | input | 1 | Framing error seen on that character |
| rd_en | input | 1 | One-cycle strobe: the host consumes the head entry |
| char_tick | input | 1 | One-cycle pulse once per character time |
| trig_sel | input | 2 | Trigger level code (see R7) |
| rd_char | output | 8 | Oldest stored character |
| rd_perr | output | 1 | Parity-error bit of the head entry |
| rd_ferr | output | 1 | Framing-error bit of the head entry |
| empty | output | 1 | Buffer holds no character |
| overrun | output | 1 | Sticky flag: a character was discarded |
| irq | output | 1 | Receive interrupt: level reached or timeout pending |

## Verification
The assertions assume that `wr_en`, `rd_en` and `char_tick` are single-cycle strobes sampled at the rising edge. They also assume that `trig_sel` changes only between transfers, so a level comparison is never made against a code that is still settling. The bench drives every input on the falling edge, and it pulses ticks in cycles that carry neither a write nor a read, so the three-tick timeout window has a definite boundary. Data on `rd_char` is checked only while `empty` is 0, because the head entry has no meaning otherwise.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Trigger code to fill level: 0->1, 1->4, 2->8, 3->14
  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  // Next pointer value with wrap at depth
  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int EW    = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [EW-1:0]                wr_entry,
  input  logic                         rd_en,
  output logic [EW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         is_empty,
  output logic                         drop
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          full, push, pop;

  assign full     = (count == CW'(DEPTH));
  assign is_empty = (count == '0);
  assign pop      = rd_en && !is_empty;
  assign push     = wr_en && (!full || pop);
  assign drop     = wr_en && full && !rd_en;
  assign head     = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= PW'(rxq_pkg::ptr_next(int'(wp), DEPTH));
      if (pop)  rp <= PW'(rxq_pkg::ptr_next(int'(rp), DEPTH));
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r4_capacity: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r5_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> count == $past(count));
  a_r12_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && is_empty && !wr_en) |=> is_empty);
endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
  parameter int TO_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic activity,
  input  logic rd_en,
  input  logic is_empty,
  input  logic tick,
  output logic to_pend
);
  localparam int TW = $clog2(TO_TICKS+1);

  logic [TW-1:0] ticks;
  logic          to_fire;

  assign to_fire = tick && !activity && !is_empty && (ticks == TW'(TO_TICKS-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ticks   <= '0;
      to_pend <= 1'b0;
    end else begin
      if (activity || is_empty)              ticks <= '0;
      else if (tick && ticks < TW'(TO_TICKS)) ticks <= ticks + 1'b1;
      if (rd_en)        to_pend <= 1'b0;
      else if (to_fire) to_pend <= 1'b1;
    end
  end

  a_r9_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_pend) |-> $past(tick));
  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !to_pend);
endmodule

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq #(
  parameter int DEPTH    = 16,
  parameter int DW       = 8,
  parameter int TO_TICKS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_char,
  input  logic          wr_perr,
  input  logic          wr_ferr,
  input  logic          rd_en,
  input  logic          char_tick,
  input  logic [1:0]    trig_sel,
  output logic [DW-1:0] rd_char,
  output logic          rd_perr,
  output logic          rd_ferr,
  output logic          empty,
  output logic          overrun,
  output logic          irq
);
  localparam int EW = DW + 2;
  localparam int CW = $clog2(DEPTH+1);

  logic [EW-1:0] head;
  logic [CW-1:0] count;
  logic          drop, to_pend, lvl_hit;

  rxq_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_entry({wr_perr, wr_ferr, wr_char}), .rd_en(rd_en),
    .head(head), .count(count), .is_empty(empty), .drop(drop));

  rxq_timeout #(.TO_TICKS(TO_TICKS)) u_to (
    .clk(clk), .rst_n(rst_n), .activity(wr_en || rd_en), .rd_en(rd_en),
    .is_empty(empty), .tick(char_tick), .to_pend(to_pend));

  assign {rd_perr, rd_ferr, rd_char} = head;
  assign lvl_hit = (int'(count) >= rxq_pkg::trig_level(trig_sel));
  assign irq     = lvl_hit || to_pend;

  always_ff @(posedge clk) begin
    if (!rst_n)     overrun <= 1'b0;
    else if (rd_en) overrun <= 1'b0;
    else if (drop)  overrun <= 1'b1;
  end

  a_r5_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(drop));
  a_r6_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !overrun);
  a_r13_no_drop_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> !$rose(overrun));
endmodule

// File: tb/sim_rx_fifo_irq.sv
module sim_rx_fifo_irq;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, wr_perr = 0, wr_ferr = 0, rd_en = 0, char_tick = 0;
  logic [7:0] wr_char = 0;
  logic [1:0] trig_sel = 0;
  logic [7:0] rd_char;
  logic       rd_perr, rd_ferr, empty, overrun, irq;
  int errs = 0, checks = 0;

  always #10 clk = ~clk;

  rx_fifo_irq u0 (.*);

  // {wr, char, rd, sel, exp_empty, exp_irq, exp_head}
  localparam logic [21:0] VEC [13] = '{
    {1'b1, 8'hA5, 1'b0, 2'd0, 1'b0, 1'b1, 8'hA5},
    {1'b1, 8'h3C, 1'b0, 2'd0, 1'b0, 1'b1, 8'hA5},
    {1'b0, 8'h00, 1'b1, 2'd0, 1'b0, 1'b1, 8'h3C},
    {1'b0, 8'h00, 1'b1, 2'd0, 1'b1, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0, 8'h00},
    {1'b1, 8'h11, 1'b0, 2'd1, 1'b0, 1'b0, 8'h11},
    {1'b1, 8'h22, 1'b0, 2'd1, 1'b0, 1'b0, 8'h11},
    {1'b1, 8'h33, 1'b0, 2'd1, 1'b0, 1'b0, 8'h11},
    {1'b1, 8'h44, 1'b0, 2'd1, 1'b0, 1'b1, 8'h11},
    {1'b0, 8'h00, 1'b1, 2'd1, 1'b0, 1'b0, 8'h22},
    {1'b0, 8'h00, 1'b1, 2'd1, 1'b0, 1'b0, 8'h33},
    {1'b0, 8'h00, 1'b1, 2'd1, 1'b0, 1'b0, 8'h44},
    {1'b0, 8'h00, 1'b1, 2'd1, 1'b1, 1'b0, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, driven at negedge, results visible at next negedge
  task automatic step(input logic w, input logic [7:0] c, input logic pe, input logic fe,
                      input logic r, input logic t);
    wr_en = w; wr_char = c; wr_perr = pe; wr_ferr = fe; rd_en = r; char_tick = t;
    @(negedge clk);
    wr_en = 0; rd_en = 0; char_tick = 0; wr_perr = 0; wr_ferr = 0;
  endtask

  initial begin
    #4_000_000;
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 empty", empty, 1); chk("R1 overrun", overrun, 0); chk("R1 irq", irq, 0);

    // vector walk: R2 order, R7 levels 1 and 4, R8 irq falls below trigger
    foreach (VEC[i]) begin
      trig_sel = VEC[i][11:10];
      step(VEC[i][21], VEC[i][20:13], 0, 0, VEC[i][12], 0);
      chk("R4 empty flag", empty, VEC[i][9]);
      chk("R7/R8 irq", irq, VEC[i][8]);
      if (!VEC[i][9]) chk("R2 head", rd_char, VEC[i][7:0]);
    end

    // R12 read on empty has no effect
    step(0, 0, 0, 0, 1, 0);
    chk("R12 still empty", empty, 1);
    step(1, 8'h5A, 0, 0, 0, 0);
    chk("R12 head", rd_char, 8'h5A);
    step(0, 0, 0, 0, 1, 0);
    chk("R12 one entry only", empty, 1);

    // fill to 16 with trigger 14; R3 error bits; R7 level 14
    trig_sel = 2'd3;
    for (int k = 0; k < 16; k++) begin
      step(1, 8'h80 + 8'(k), k[0], k[1], 0, 0);
      if (k == 12) chk("R7 irq below 14", irq, 0);
      if (k == 13) chk("R7 irq at 14", irq, 1);
    end
    chk("R3 perr head", rd_perr, 0); chk("R3 ferr head", rd_ferr, 0);
    // R5/R6 overflow
    step(1, 8'hEE, 0, 0, 0, 0);
    chk("R6 overrun set", overrun, 1);
    chk("R5 head kept", rd_char, 8'h80);
    for (int k = 0; k < 16; k++) begin
      chk("R5 order after drop", rd_char, 8'h80 + 8'(k));
      chk("R3 perr", rd_perr, k[0]); chk("R3 ferr", rd_ferr, k[1]);
      step(0, 0, 0, 0, 1, 0);
      if (k == 0) chk("R6 overrun cleared", overrun, 0);
      if (k == 2) chk("R8 irq below 14", irq, 0);
    end
    chk("R5 drained, dropped char gone", empty, 1);

    // R13 simultaneous read/write on full
    for (int k = 0; k < 16; k++) step(1, 8'h40 + 8'(k), 0, 0, 0, 0);
    step(1, 8'h77, 0, 0, 1, 0);
    chk("R13 no overrun", overrun, 0);
    chk("R13 head advanced", rd_char, 8'h41);
    for (int k = 0; k < 15; k++) step(0, 0, 0, 0, 1, 0);
    chk("R13 new char stored", rd_char, 8'h77);
    step(0, 0, 0, 0, 1, 0);
    chk("R13 empty", empty, 1);

    // R9 timeout after three ticks
    step(1, 8'h61, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1); step(0, 0, 0, 0, 0, 1);
    chk("R9 no irq after 2 ticks", irq, 0);
    step(0, 0, 0, 0, 0, 1);
    chk("R9 irq after 3 ticks", irq, 1);
    // R11 read clears; one char remains below trigger? refill to two first
    step(1, 8'h62, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    chk("R11 timeout cleared", irq, 0);
    // R10 restart on write
    step(0, 0, 0, 0, 0, 1); step(0, 0, 0, 0, 0, 1);
    step(1, 8'h63, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1); step(0, 0, 0, 0, 0, 1);
    chk("R10 restarted by write", irq, 0);
    step(0, 0, 0, 0, 0, 1);
    chk("R10 fires after 3 ticks", irq, 1);
    // R10 restart on read
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1); step(0, 0, 0, 0, 0, 1);
    chk("R10 restarted by read", irq, 0);
    step(0, 0, 0, 0, 0, 1);
    chk("R10 fires after read", irq, 1);
    chk("R2 remaining head", rd_char, 8'h63);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule